// File: doc/BRIEF.md
# Secret-Region Cache-Miss Attack Monitor

This block sits beside a processor core and watches the stream of cache misses for signs of an eviction-style timing attack on code or data that software has marked as secret. Each miss arrives as a strobe plus the address that missed. Software programs one register set per monitored region. Each set holds the secret line address, the longest allowed gap between two suspicious misses, and a detection threshold. A single sample period is shared by all regions. A miss counts against a region only when its cache line matches the region's secret line and it follows the region's previous matching miss closely enough. An attacker has to evict the secret line over and over, so the victim sees fast, repeated misses on that line. Ordinary code produces sparse misses, and those are ignored.

The region counters restart from zero whenever a sample window has elapsed. When a region's counter rises above its threshold, the region's sticky fired flag is set and the shared interrupt line rises. It stays high until software acknowledges it. Setting a threshold of zero disables detection for that region. The per-region counters are brought out so that the monitor's progress is visible.

Top module: `cache_attack_monitor`

## Requirements
- R1: After reset, and in the cycle after `cfg_clr_i`, every counter is zero, every fired flag is clear, `irq_o` is low, and all region and period registers are zero.
- R2: A miss matches a region when `miss_addr_i[ADDR_W-1:LINE_BITS]` equals the region's secret address in the same bits. A miss affects only matching regions, and all matching regions update in the same cycle.
- R3: The first matching miss on a region after reset or clear only records its time stamp. It never increments the counter.
- R4: A later matching miss increments the counter by one if the number of cycles since the region's previous matching miss is at most the region's limit register. Otherwise the counter does not change. Every matching miss refreshes the time stamp.
- R5: On a miss cycle, if the window timer (cycles since the window started, saturating) is at least the period register, all counters restart from zero and the window restarts. The increment for that miss is still applied. Without a miss, counters are never cleared by the window.
- R6: In the cycle after a counter exceeds a nonzero threshold, the region's `fired_o` bit sets. The bit is sticky, and `irq_o` is the OR of all fired bits.
- R7: Once a counter exceeds its threshold, or its region has fired, that counter stops incrementing.
- R8: A threshold of zero never sets the fired bit. The 8-bit counter then wraps from 255 to 0.
- R9: `ack_i` clears all fired bits and all counters in the next cycle, and keeps time stamps and configuration.
- R10: Configuration writes use `cfg_we_i`, `cfg_sel_i` (region index) and `cfg_field_i`, and take effect in the next cycle. The field codes are: 0 = secret address, 1 = gap limit (low TIME_W bits), 2 = threshold (low 8 bits), 3 = shared sample period (low TIME_W bits; region index ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | SEL_W | Region index of the write |
| cfg_field_i | input | 2 | Register field code |
| cfg_wdata_i | input | ADDR_W | Write data |
| cfg_clr_i | input | 1 | Clear all registers and state |
| ack_i | input | 1 | Acknowledge: clear fired bits and counters |
| miss_vld_i | input | 1 | Cache-miss strobe |
| miss_addr_i | input | ADDR_W | Address of the missing access |
| irq_o | output | 1 | Attack-detected interrupt |
| fired_o | output | NUM_REGIONS | Sticky per-region fired bits |
| count_o | output | 8*NUM_REGIONS | Per-region counters, region r in bits [8r+7:8r] |

## Verification
The assertions check the per-cycle properties on every clock. A counter moves only on a miss cycle, by at most one outside a window restart. A fired counter stays frozen. Fired bits are sticky. A zero threshold never raises a fired bit. What the bench must show through scenarios is the interplay of time: the first miss that only records its stamp, the gap limit at its exact boundary, a window that restarts only when a miss arrives, overlapping regions counting together, and the 255-to-0 wrap of a disabled region.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int CNT_W = 8;
  typedef enum logic [1:0] {
    FLD_ADDR   = 2'd0,
    FLD_LIMIT  = 2'd1,
    FLD_THRESH = 2'd2,
    FLD_PERIOD = 2'd3
  } cfg_field_e;
endpackage

// File: rtl/cam_window_timer.sv
module cam_window_timer #(
  parameter int TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              miss_i,
  input  logic [TIME_W-1:0] period_i,
  output logic [TIME_W-1:0] now_o,
  output logic              expire_o
);
  localparam logic [TIME_W-1:0] WIN_MAX = '1;

  logic [TIME_W-1:0] now_q, win_q;

  assign now_o    = now_q;
  assign expire_o = miss_i && (win_q >= period_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q <= '0;
      win_q <= '0;
    end else if (clr_i) begin
      now_q <= '0;
      win_q <= '0;
    end else begin
      now_q <= now_q + 1'b1;
      if (expire_o)            win_q <= '0;
      else if (win_q != WIN_MAX) win_q <= win_q + 1'b1;
    end
  end

  // R5
  win_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !clr_i) |=> (win_q == '0));
endmodule

// File: rtl/cam_region.sv
module cam_region
  import cam_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int TIME_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              ack_i,
  input  logic              we_i,
  input  cfg_field_e        field_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              miss_i,
  input  logic [ADDR_W-LINE_BITS-1:0] miss_line_i,
  input  logic              expire_i,
  input  logic [TIME_W-1:0] now_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              fired_o
);
  localparam int LINE_W = ADDR_W - LINE_BITS;

  logic [LINE_W-1:0] line_q;
  logic [LINE_BITS-1:0] addr_lo_q;
  logic [TIME_W-1:0] lim_q, ts_q, gap;
  logic [CNT_W-1:0]  thr_q, cnt_q, cnt_base;
  logic              ts_vld_q, fired_q;
  logic              match, over, inc;

  assign match    = miss_i && (miss_line_i == line_q);
  assign gap      = now_i - ts_q;
  assign over     = (thr_q != '0) && (cnt_q > thr_q);
  assign inc      = match && ts_vld_q && (gap <= lim_q) && !fired_q && !over;
  assign cnt_base = (ack_i || expire_i) ? '0 : cnt_q;

  assign cnt_o   = cnt_q;
  assign fired_o = fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0; addr_lo_q <= '0; lim_q <= '0; thr_q <= '0;
      ts_q <= '0; ts_vld_q <= 1'b0; cnt_q <= '0; fired_q <= 1'b0;
    end else if (clr_i) begin
      line_q <= '0; addr_lo_q <= '0; lim_q <= '0; thr_q <= '0;
      ts_q <= '0; ts_vld_q <= 1'b0; cnt_q <= '0; fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_base + CNT_W'(inc);
      fired_q <= ack_i ? 1'b0 : (fired_q | over);
      if (match) begin
        ts_q     <= now_i;
        ts_vld_q <= 1'b1;
      end
      if (we_i) begin
        case (field_i)
          FLD_ADDR:   {line_q, addr_lo_q} <= wdata_i;
          FLD_LIMIT:  lim_q <= wdata_i[TIME_W-1:0];
          FLD_THRESH: thr_q <= wdata_i[CNT_W-1:0];
          default:    ;
        endcase
      end
    end
  end

  // R2
  cnt_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_i && !clr_i && !ack_i) |=> $stable(cnt_q));
  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !expire_i && !clr_i && !ack_i) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R7
  cnt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !clr_i && !ack_i && !expire_i) |=> $stable(cnt_q));
  // R6
  fired_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fired_q && !clr_i && !ack_i) |=> fired_q);
  // R8
  thr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_q == '0 && !fired_q) |=> !fired_q);
endmodule

// File: rtl/cache_attack_monitor.sv
module cache_attack_monitor
  import cam_pkg::*;
#(
  parameter int NUM_REGIONS = 3,
  parameter int ADDR_W      = 32,
  parameter int LINE_BITS   = 6,
  parameter int TIME_W      = 16,
  localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cfg_we_i,
  input  logic [SEL_W-1:0]             cfg_sel_i,
  input  logic [1:0]                   cfg_field_i,
  input  logic [ADDR_W-1:0]            cfg_wdata_i,
  input  logic                         cfg_clr_i,
  input  logic                         ack_i,
  input  logic                         miss_vld_i,
  input  logic [ADDR_W-1:0]            miss_addr_i,
  output logic                         irq_o,
  output logic [NUM_REGIONS-1:0]       fired_o,
  output logic [CNT_W*NUM_REGIONS-1:0] count_o
);
  cfg_field_e        field;
  logic [TIME_W-1:0] period_q, now;
  logic              expire;
  logic [LINE_BITS-1:0] miss_lo_unused;

  assign field          = cfg_field_e'(cfg_field_i);
  assign miss_lo_unused = miss_addr_i[LINE_BITS-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   period_q <= '0;
    else if (cfg_clr_i)                            period_q <= '0;
    else if (cfg_we_i && field == FLD_PERIOD)      period_q <= cfg_wdata_i[TIME_W-1:0];
  end

  cam_window_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cfg_clr_i),
    .miss_i   (miss_vld_i),
    .period_i (period_q),
    .now_o    (now),
    .expire_o (expire)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic sel;
    assign sel = cfg_we_i && (cfg_sel_i == SEL_W'(r));
    cam_region #(
      .ADDR_W    (ADDR_W),
      .LINE_BITS (LINE_BITS),
      .TIME_W    (TIME_W)
    ) u_region (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (cfg_clr_i),
      .ack_i       (ack_i),
      .we_i        (sel),
      .field_i     (field),
      .wdata_i     (cfg_wdata_i),
      .miss_i      (miss_vld_i),
      .miss_line_i (miss_addr_i[ADDR_W-1:LINE_BITS]),
      .expire_i    (expire),
      .now_i       (now),
      .cnt_o       (count_o[r*CNT_W +: CNT_W]),
      .fired_o     (fired_o[r])
    );
  end

  assign irq_o = |fired_o;

  // R9
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !cfg_clr_i) |=> !irq_o);
  // R1
  clr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_clr_i |=> (count_o == '0 && fired_o == '0));
endmodule

// File: tb/cache_attack_monitor_bench.sv
module cache_attack_monitor_bench;
  localparam int N = 3;
  localparam int AW = 32;
  localparam int LB = 6;
  localparam int TMASK = 16'hFFFF;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, cfg_clr = 0, ack = 0, miss = 0;
  logic [1:0] cfg_sel = 0, cfg_field = 0;
  logic [AW-1:0] cfg_wdata = 0, miss_addr = 0;
  logic irq;
  logic [N-1:0] fired;
  logic [8*N-1:0] count;

  always #4 clk = ~clk;

  cache_attack_monitor #(.NUM_REGIONS(N), .ADDR_W(AW), .LINE_BITS(LB), .TIME_W(16)) u_cache_attack_monitor (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_field_i(cfg_field), .cfg_wdata_i(cfg_wdata), .cfg_clr_i(cfg_clr),
    .ack_i(ack), .miss_vld_i(miss), .miss_addr_i(miss_addr),
    .irq_o(irq), .fired_o(fired), .count_o(count));

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";

  // reference state
  int m_now = 0, m_win = 0, m_per = 0;
  int m_cnt[N], m_ts[N], m_lim[N], m_thr[N];
  bit m_tv[N], m_flag[N];
  logic [AW-1:0] m_addr[N];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic model_clear();
    m_now = 0; m_win = 0; m_per = 0;
    for (int r = 0; r < N; r++) begin
      m_cnt[r] = 0; m_ts[r] = 0; m_lim[r] = 0; m_thr[r] = 0;
      m_tv[r] = 0; m_flag[r] = 0; m_addr[r] = 0;
    end
  endtask

  task automatic tick();
    bit expire;
    expire = miss && (m_win >= m_per);
    if (cfg_clr) model_clear();
    else begin
      for (int r = 0; r < N; r++) begin
        bit match, over, inc;
        int gap, base;
        match = miss && ((miss_addr >> LB) == (m_addr[r] >> LB));
        gap = (m_now - m_ts[r]) & TMASK;
        over = (m_thr[r] != 0) && (m_cnt[r] > m_thr[r]);
        inc = match && m_tv[r] && (gap <= m_lim[r]) && !m_flag[r] && !over;
        base = (ack || expire) ? 0 : m_cnt[r];
        m_cnt[r] = (base + int'(inc)) % 256;
        if (match) begin m_ts[r] = m_now; m_tv[r] = 1; end
        m_flag[r] = ack ? 0 : (m_flag[r] | over);
      end
      m_now = (m_now + 1) & TMASK;
      m_win = expire ? 0 : ((m_win == TMASK) ? m_win : m_win + 1);
      if (cfg_we) begin
        case (cfg_field)
          2'd0: m_addr[cfg_sel] = cfg_wdata;
          2'd1: m_lim[cfg_sel] = int'(cfg_wdata[15:0]);
          2'd2: m_thr[cfg_sel] = int'(cfg_wdata[7:0]);
          default: m_per = int'(cfg_wdata[15:0]);
        endcase
      end
    end
    @(posedge clk); #1;
    cycles++;
    for (int r = 0; r < N; r++) begin
      chk(int'(count[r*8 +: 8]) == m_cnt[r], cur_req, int'(count[r*8 +: 8]), m_cnt[r]);
      chk(fired[r] == m_flag[r], cur_req, int'(fired[r]), int'(m_flag[r]));
    end
    chk(irq == (m_flag[0] | m_flag[1] | m_flag[2]), cur_req, int'(irq),
        int'(m_flag[0] | m_flag[1] | m_flag[2]));
  endtask

  task automatic wr(int sel, int fld, logic [AW-1:0] d);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_field = 2'(fld); cfg_wdata = d;
    tick();
    cfg_we = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // miss that arrives gap cycles after the previous tick's miss
  task automatic miss_gap(logic [AW-1:0] a, int gap);
    idle(gap - 1);
    miss = 1; miss_addr = a;
    tick();
    miss = 0;
  endtask

  task automatic cnt_is(int r, int exp, string req);
    chk(int'(count[r*8 +: 8]) == exp, req, int'(count[r*8 +: 8]), exp);
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    // R1 reset state
    cur_req = "R1";
    chk(count == '0, "R1", int'(count), 0);
    chk(fired == '0 && !irq, "R1", int'(fired), 0);
    idle(2);

    // R10 configuration
    cur_req = "R10";
    wr(0, 0, 32'h1000); wr(0, 1, 10); wr(0, 2, 3);
    wr(1, 0, 32'h2040); wr(1, 1, 5);  wr(1, 2, 2);
    wr(2, 0, 32'h1020); wr(2, 1, 10); wr(2, 2, 0);
    wr(0, 3, 1000);

    // R3 first miss only stamps; R2 overlapping regions 0 and 2 count together
    cur_req = "R3";
    miss_gap(32'h1008, 2);
    cnt_is(0, 0, "R3"); cnt_is(2, 0, "R3");
    cur_req = "R2";
    for (int i = 0; i < 4; i++) miss_gap(32'h1030, 4);
    cnt_is(0, 4, "R2"); cnt_is(2, 4, "R2"); cnt_is(1, 0, "R2");
    // R6 flag appears one cycle later
    cur_req = "R6";
    chk(fired[0] == 0, "R6", int'(fired[0]), 0);
    idle(1);
    chk(fired == 3'b001 && irq, "R6", int'(fired), 1);
    // R7 frozen after detection, R8 disabled region keeps counting
    cur_req = "R7";
    miss_gap(32'h1000, 3);
    cnt_is(0, 4, "R7"); cnt_is(2, 5, "R8");
    // non-matching address
    cur_req = "R2";
    miss_gap(32'h3000, 2);
    cnt_is(2, 5, "R2");

    // R4 gap limit on region 1 (limit 5)
    cur_req = "R4";
    miss_gap(32'h2050, 2);
    miss_gap(32'h2040, 8);
    miss_gap(32'h2040, 6);
    cnt_is(1, 0, "R4");
    miss_gap(32'h2040, 5);
    cnt_is(1, 1, "R4");
    miss_gap(32'h207F, 6);
    cnt_is(1, 1, "R4");

    // R9 acknowledge
    cur_req = "R9";
    ack = 1; tick(); ack = 0;
    chk(fired == '0 && !irq, "R9", int'(fired), 0);
    cnt_is(0, 0, "R9");

    // R5 window restart only on a miss
    cur_req = "R5";
    wr(1, 2, 200); wr(0, 3, 20);
    miss_gap(32'h2040, 2);
    for (int i = 0; i < 3; i++) miss_gap(32'h2040, 4);
    idle(30);
    chk(count[15:8] != 0, "R5", int'(count[15:8]), 1);
    miss_gap(32'h9000, 1);
    cnt_is(1, 0, "R5");
    for (int i = 0; i < 12; i++) miss_gap(32'h2040, 3);

    // R8 wrap of a disabled region
    cur_req = "R8";
    wr(0, 3, 60000);
    ack = 1; tick(); ack = 0;
    miss_gap(32'h1020, 2);
    for (int i = 0; i < 255; i++) miss_gap(32'h1020, 2);
    cnt_is(2, 255, "R8");
    miss_gap(32'h1020, 2);
    cnt_is(2, 0, "R8");
    chk(fired[2] == 0, "R8", int'(fired[2]), 0);

    // R1 clear strobe, then R3 again
    cur_req = "R1";
    cfg_clr = 1; tick(); cfg_clr = 0;
    chk(count == '0 && fired == '0 && !irq, "R1", int'(count), 0);
    cur_req = "R3";
    wr(0, 0, 32'h1000); wr(0, 1, 10); wr(0, 3, 500);
    miss_gap(32'h1000, 2);
    cnt_is(0, 0, "R3");
    miss_gap(32'h1000, 3);
    cnt_is(0, 1, "R4");
    idle(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule